// File: doc/BRIEF.md
# Cross-domain time-of-day synchronizer

This block carries a free-running 96-bit time-of-day value from a master clock domain into a slave clock domain. The master time enters a dual-clock FIFO on every master cycle. The slave side drains the FIFO on every slave cycle, so a value reaching the slave is always a few cycles old. The master clock keeps counting during that time.

A third clock runs slightly faster than the master and slave clocks, at 64/63 of their rate. On each synchronization request it samples the FIFO fill level 64 times. Because of the frequency offset, the sample phase slides across a whole clock period during that window, so the summed fill level gives a fine-grained latency estimate.

The slave side converts the average fill level into time using the master clock period. It adds a fixed pipeline allowance and adds the result to the value at the FIFO head. It then presents the compensated time together with a one-cycle strobe, and the slave time counter loads itself from that strobe.

Top module: `tod_xdomain_sync`

## Requirements
- R1: After slave reset, valid_o is 0 and tod_o is all zeros.
- R2: Only a rising edge of start_i opens a window. A start held high, or a second rising edge while a window is open, produces exactly one valid_o strobe for that window.
- R3: valid_o is high for exactly one slave cycle per window.
- R4: valid_o rises between 64 and 80 slave cycles after the slave cycle in which start_i rises, because a window is 64 sampling-clock cycles.
- R5: The time format is seconds in tod_o[95:48], nanoseconds in tod_o[47:16] and fractional nanoseconds (units of 2^-16 ns) in tod_o[15:0]. The nanosecond field delivered with valid_o is always below 1,000,000,000, and the overflow carries into the seconds field.
- R6: The delivered time equals the FIFO head value plus (sum of the 64 fill samples × PERIOD_FNS / 64) plus EXTRA_CYC × PERIOD_FNS. With equal master and slave clocks this keeps it within 15 ns of the master time at the slave cycle of valid_o. The fill level seen by the sampling clock never exceeds the FIFO depth.
- R7: tod_o changes only in the cycle in which valid_o is high, and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m_i | input | 1 | Master clock |
| rst_m_ni | input | 1 | Master-domain asynchronous reset, active low |
| tod_m_i | input | 96 | Master time of day |
| clk_s_i | input | 1 | Slave clock |
| rst_s_ni | input | 1 | Slave-domain asynchronous reset, active low |
| start_i | input | 1 | Synchronization request, acted on at its rising edge |
| valid_o | output | 1 | One-cycle strobe that marks a compensated time |
| tod_o | output | 96 | Compensated time of day for the slave counter |
| clk_samp_i | input | 1 | Sampling clock, 64/63 of the master rate |
| rst_samp_ni | input | 1 | Sampling-domain asynchronous reset, active low |

## Verification
The hardest case to reach from the ports is a window in which the compensated value crosses a second boundary. The head value and the measured latency must then combine to push the nanosecond field past one billion.

The bench reaches this case by jumping its master time model to a few hundred nanoseconds before a second. It lets the FIFO refill with the new values and then opens a window, so the strobe falls after the wrap. The delivered seconds and nanoseconds are compared with the master model at that moment.

A held start and a second start inside an open window are driven to show that no extra strobe appears.

// File: rtl/tod_sync_pkg.sv
package tod_sync_pkg;
  localparam int TOD_W = 96;
  localparam logic [48:0] SEC_FNS = 49'd65536000000000;

  typedef struct packed {
    logic [47:0] sec;
    logic [31:0] ns;
    logic [15:0] frac;
  } tod_t;

  // add a sub-second offset in fractional ns, carry ns into seconds
  function automatic tod_t tod_add_fns(tod_t t, logic [47:0] d);
    logic [48:0] s;
    tod_t r;
    s = {1'b0, t.ns, t.frac} + {1'b0, d};
    r.sec = t.sec;
    if (s >= SEC_FNS) begin
      s = s - SEC_FNS;
      r.sec = t.sec + 48'd1;
    end
    r.ns   = s[47:16];
    r.frac = s[15:0];
    return r;
  endfunction
endpackage

// File: rtl/tod_sync_cdc.sv
module tod_sync_cdc #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/tod_sync_fifo.sv
module tod_sync_fifo #(
  parameter int DEPTH_LOG2 = 4,
  parameter int W          = 96,
  localparam int PW        = DEPTH_LOG2 + 1,
  localparam int DEPTH     = 1 << DEPTH_LOG2
) (
  input  logic          wclk_i,
  input  logic          wrst_ni,
  input  logic [W-1:0]  wdata_i,
  input  logic          rclk_i,
  input  logic          rrst_ni,
  output logic [W-1:0]  rdata_o,
  output logic [PW-1:0] wptr_gray_o,
  output logic [PW-1:0] rptr_gray_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wb_q, wg_q, rb_q, rg_q;
  logic [PW-1:0] rg_w, wg_r;
  logic          full, empty;
  logic [W-1:0]  rdata_q;

  function automatic logic [PW-1:0] b2g(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  tod_sync_cdc #(.W(PW), .STAGES(2)) i_rptr_to_w (
    .clk_i(wclk_i), .rst_ni(wrst_ni), .d_i(rg_q), .q_o(rg_w)
  );
  tod_sync_cdc #(.W(PW), .STAGES(2)) i_wptr_to_r (
    .clk_i(rclk_i), .rst_ni(rrst_ni), .d_i(wg_q), .q_o(wg_r)
  );

  // write side: push every master cycle unless full
  assign full = (wg_q == {~rg_w[PW-1:PW-2], rg_w[PW-3:0]});

  always_ff @(posedge wclk_i) begin
    if (!full) mem[wb_q[DEPTH_LOG2-1:0]] <= wdata_i;
  end

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wb_q <= '0;
      wg_q <= '0;
    end else if (!full) begin
      wb_q <= wb_q + 1'b1;
      wg_q <= b2g(wb_q + 1'b1);
    end
  end

  // read side: pop every slave cycle unless empty, head held in a register
  assign empty = (rg_q == wg_r);

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rb_q    <= '0;
      rg_q    <= '0;
      rdata_q <= '0;
    end else if (!empty) begin
      rdata_q <= mem[rb_q[DEPTH_LOG2-1:0]];
      rb_q    <= rb_q + 1'b1;
      rg_q    <= b2g(rb_q + 1'b1);
    end
  end

  assign rdata_o     = rdata_q;
  assign wptr_gray_o = wg_q;
  assign rptr_gray_o = rg_q;
endmodule

// File: rtl/tod_fill_sampler.sv
module tod_fill_sampler #(
  parameter int DEPTH_LOG2 = 4,
  parameter int WIN_LOG2   = 6,
  localparam int PW        = DEPTH_LOG2 + 1,
  localparam int SW        = PW + WIN_LOG2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] wptr_gray_i,
  input  logic [PW-1:0] rptr_gray_i,
  input  logic          req_tgl_i,
  output logic          ack_tgl_o,
  output logic [SW-1:0] sum_o,
  output logic [PW-1:0] fill_o
);
  logic [PW-1:0]       wg_s, rg_s, wb, rb, fill;
  logic                req_s, req_seen_q, active_q, ack_q;
  logic [WIN_LOG2-1:0] cnt_q;
  logic [SW-1:0]       acc_q, sum_q;

  function automatic logic [PW-1:0] g2b(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  tod_sync_cdc #(.W(PW), .STAGES(2)) i_wptr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wptr_gray_i), .q_o(wg_s)
  );
  tod_sync_cdc #(.W(PW), .STAGES(2)) i_rptr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rptr_gray_i), .q_o(rg_s)
  );
  tod_sync_cdc #(.W(1), .STAGES(2)) i_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_tgl_i), .q_o(req_s)
  );

  assign wb   = g2b(wg_s);
  assign rb   = g2b(rg_s);
  assign fill = wb - rb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_seen_q <= 1'b0;
      active_q   <= 1'b0;
      ack_q      <= 1'b0;
      cnt_q      <= '0;
      acc_q      <= '0;
      sum_q      <= '0;
    end else begin
      req_seen_q <= req_s;
      if (active_q) begin
        acc_q <= acc_q + SW'(fill);
        cnt_q <= cnt_q + 1'b1;
        if (&cnt_q) begin
          active_q <= 1'b0;
          sum_q    <= acc_q + SW'(fill);
          ack_q    <= ~ack_q;
        end
      end else if (req_s != req_seen_q) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        acc_q    <= '0;
      end
    end
  end

  assign ack_tgl_o = ack_q;
  assign sum_o     = sum_q;
  assign fill_o    = fill;
endmodule

// File: rtl/tod_slave_ctrl.sv
module tod_slave_ctrl
  import tod_sync_pkg::*;
#(
  parameter int SW         = 11,
  parameter int WIN_LOG2   = 6,
  parameter int PERIOD_FNS = 655360,
  parameter int EXTRA_CYC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TOD_W-1:0] head_i,
  input  logic [SW-1:0]    sum_i,
  input  logic             ack_tgl_i,
  output logic             req_tgl_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [TOD_W-1:0] tod_o
);
  logic        start_q, busy_q, req_q, ack_s, ack_seen_q, valid_q;
  tod_t        tod_q;
  logic [47:0] lat;

  tod_sync_cdc #(.W(1), .STAGES(2)) i_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_tgl_i), .q_o(ack_s)
  );

  // average occupancy times period, plus fixed pipeline allowance
  assign lat = ((48'(sum_i) * 48'(PERIOD_FNS)) >> WIN_LOG2)
             + 48'(EXTRA_CYC) * 48'(PERIOD_FNS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q    <= 1'b0;
      busy_q     <= 1'b0;
      req_q      <= 1'b0;
      ack_seen_q <= 1'b0;
      valid_q    <= 1'b0;
      tod_q      <= '0;
    end else begin
      start_q    <= start_i;
      ack_seen_q <= ack_s;
      valid_q    <= 1'b0;
      if (busy_q && (ack_s != ack_seen_q)) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
        tod_q   <= tod_add_fns(tod_t'(head_i), lat);
      end else if (start_i && !start_q && !busy_q) begin
        busy_q <= 1'b1;
        req_q  <= ~req_q;
      end
    end
  end

  assign req_tgl_o = req_q;
  assign busy_o    = busy_q;
  assign valid_o   = valid_q;
  assign tod_o     = tod_q;
endmodule

// File: rtl/tod_xdomain_sync.sv
module tod_xdomain_sync
  import tod_sync_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4,
  parameter int WIN_LOG2   = 6,
  parameter int PERIOD_FNS = 655360,
  parameter int EXTRA_CYC  = 2,
  localparam int PW        = DEPTH_LOG2 + 1,
  localparam int SW        = PW + WIN_LOG2
) (
  input  logic        clk_m_i,
  input  logic        rst_m_ni,
  input  logic [95:0] tod_m_i,
  input  logic        clk_s_i,
  input  logic        rst_s_ni,
  input  logic        start_i,
  output logic        valid_o,
  output logic [95:0] tod_o,
  input  logic        clk_samp_i,
  input  logic        rst_samp_ni
);
  logic [PW-1:0]    wptr_gray, rptr_gray, fill;
  logic [TOD_W-1:0] head;
  logic [SW-1:0]    sum;
  logic             req_tgl, ack_tgl, busy;

  tod_sync_fifo #(.DEPTH_LOG2(DEPTH_LOG2), .W(TOD_W)) i_fifo (
    .wclk_i(clk_m_i), .wrst_ni(rst_m_ni), .wdata_i(tod_m_i),
    .rclk_i(clk_s_i), .rrst_ni(rst_s_ni), .rdata_o(head),
    .wptr_gray_o(wptr_gray), .rptr_gray_o(rptr_gray)
  );

  tod_fill_sampler #(.DEPTH_LOG2(DEPTH_LOG2), .WIN_LOG2(WIN_LOG2)) i_sampler (
    .clk_i(clk_samp_i), .rst_ni(rst_samp_ni),
    .wptr_gray_i(wptr_gray), .rptr_gray_i(rptr_gray),
    .req_tgl_i(req_tgl), .ack_tgl_o(ack_tgl), .sum_o(sum), .fill_o(fill)
  );

  tod_slave_ctrl #(
    .SW(SW), .WIN_LOG2(WIN_LOG2), .PERIOD_FNS(PERIOD_FNS), .EXTRA_CYC(EXTRA_CYC)
  ) i_ctrl (
    .clk_i(clk_s_i), .rst_ni(rst_s_ni), .start_i(start_i), .head_i(head),
    .sum_i(sum), .ack_tgl_i(ack_tgl), .req_tgl_o(req_tgl), .busy_o(busy),
    .valid_o(valid_o), .tod_o(tod_o)
  );
endmodule

// File: rtl/tod_xdomain_sync_chk.sv
module tod_xdomain_sync_chk #(
  parameter int DEPTH_LOG2 = 4,
  localparam int PW        = DEPTH_LOG2 + 1
) (
  input logic          clk_s_i,
  input logic          rst_s_ni,
  input logic          clk_samp_i,
  input logic          rst_samp_ni,
  input logic          valid_o,
  input logic [95:0]   tod_o,
  input logic          busy,
  input logic          req_tgl,
  input logic [PW-1:0] fill
);
  p_single_strobe_r3: assert property (@(posedge clk_s_i) disable iff (!rst_s_ni)
    valid_o |=> !valid_o);

  p_ns_range_r5: assert property (@(posedge clk_s_i) disable iff (!rst_s_ni)
    valid_o |-> (tod_o[47:16] < 32'd1000000000));

  p_hold_r7: assert property (@(posedge clk_s_i) disable iff (!rst_s_ni)
    !$stable(tod_o) |-> valid_o);

  p_ignore_busy_r2: assert property (@(posedge clk_s_i) disable iff (!rst_s_ni)
    (busy && $past(busy)) |-> $stable(req_tgl));

  p_strobe_ends_window_r4: assert property (@(posedge clk_s_i) disable iff (!rst_s_ni)
    valid_o |-> $past(busy));

  p_fill_bound_r6: assert property (@(posedge clk_samp_i) disable iff (!rst_samp_ni)
    fill <= PW'(1 << DEPTH_LOG2));
endmodule

bind tod_xdomain_sync tod_xdomain_sync_chk #(.DEPTH_LOG2(DEPTH_LOG2)) i_chk (
  .clk_s_i(clk_s_i), .rst_s_ni(rst_s_ni), .clk_samp_i(clk_samp_i),
  .rst_samp_ni(rst_samp_ni), .valid_o(valid_o), .tod_o(tod_o),
  .busy(busy), .req_tgl(req_tgl), .fill(fill)
);

// File: tb/test_tod_xdomain_sync.sv
`timescale 1ns/1ps
module test_tod_xdomain_sync;
  localparam longint SEC_FNS = 64'd65536000000000;
  localparam longint STEP    = 64'd655360;
  localparam longint TOL     = 64'd15 * 64'd65536;

  logic        clk_m = 0, clk_s = 0, clk_samp = 0;
  logic        rst_m_n = 0, rst_s_n = 0, rst_samp_n = 0;
  logic [95:0] tod_m;
  logic        start = 0;
  logic        valid;
  logic [95:0] tod_s;

  int     errors = 0, checks = 0;
  int     cyc = 0, start_cyc = 0, n_valid = 0;
  bit     prev_valid = 0, mon_on = 0, jump_pend = 0;
  longint m_fns = 0, jump_val = 0;
  logic [95:0] held = '0;

  tod_xdomain_sync i_tod_xdomain_sync (
    .clk_m_i(clk_m), .rst_m_ni(rst_m_n), .tod_m_i(tod_m),
    .clk_s_i(clk_s), .rst_s_ni(rst_s_n), .start_i(start),
    .valid_o(valid), .tod_o(tod_s),
    .clk_samp_i(clk_samp), .rst_samp_ni(rst_samp_n)
  );

  always #5 clk_m = ~clk_m;
  initial begin
    #3;
    forever #5 clk_s = ~clk_s;
  end
  always #4.922 clk_samp = ~clk_samp;

  function automatic logic [95:0] to_tod(longint f);
    return {48'(f / SEC_FNS), 48'(f % SEC_FNS)};
  endfunction

  function automatic longint from_tod(logic [95:0] t);
    return longint'(t[95:48]) * SEC_FNS + longint'(t[47:0]);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // master time model: advances one period per master cycle
  always @(negedge clk_m) begin
    if (jump_pend) begin
      m_fns = jump_val;
      jump_pend = 0;
    end else begin
      m_fns = m_fns + STEP;
    end
    tod_m = to_tod(m_fns);
  end

  // per-clock comparison on the slave side
  always @(negedge clk_s) begin
    cyc++;
    if (mon_on) begin
      if (valid) begin
        longint err;
        n_valid++;
        chk(prev_valid == 0, "R3", prev_valid, 0);
        chk((cyc - start_cyc) >= 64 && (cyc - start_cyc) <= 80, "R4",
            cyc - start_cyc, 72);
        chk(tod_s[47:16] < 32'd1000000000, "R5", tod_s[47:16], 999999999);
        err = from_tod(tod_s) - m_fns;
        chk(err <= TOL && err >= -TOL, "R6", from_tod(tod_s), m_fns);
        held = tod_s;
      end else begin
        chk(tod_s == held, "R7", from_tod(tod_s), from_tod(held));
      end
    end
    prev_valid = valid;
  end

  task automatic wait_s(int n);
    repeat (n) @(posedge clk_s);
    #1;
  endtask

  task automatic pulse_start();
    start = 1;
    start_cyc = cyc;
    wait_s(1);
    start = 0;
  endtask

  task automatic set_master(longint v);
    jump_val = v;
    jump_pend = 1;
  endtask

  initial begin
    m_fns = 64'd3 * SEC_FNS + 64'd123456789 * 64'd65536;
    tod_m = to_tod(m_fns);
    #42;
    rst_m_n = 1; rst_s_n = 1; rst_samp_n = 1;
    wait_s(5);
    // R1: reset state
    chk(valid == 0, "R1", valid, 0);
    chk(tod_s == '0, "R1", from_tod(tod_s), 0);
    wait_s(40);
    mon_on = 1;

    // single pulse
    n_valid = 0;
    pulse_start();
    wait_s(250);
    chk(n_valid == 1, "R2", n_valid, 1);

    // start held high for longer than two windows
    n_valid = 0;
    start = 1;
    start_cyc = cyc;
    wait_s(300);
    start = 0;
    wait_s(20);
    chk(n_valid == 1, "R2", n_valid, 1);

    // second rising edge inside an open window
    n_valid = 0;
    pulse_start();
    wait_s(20);
    start = 1;
    wait_s(1);
    start = 0;
    wait_s(250);
    chk(n_valid == 1, "R2", n_valid, 1);

    // nanosecond wrap across the window: R5 carry
    set_master(64'd7 * SEC_FNS + 64'd999999500 * 64'd65536);
    wait_s(30);
    n_valid = 0;
    pulse_start();
    wait_s(250);
    chk(n_valid == 1, "R2", n_valid, 1);
    chk(tod_s[95:48] == 48'd8, "R5", longint'(tod_s[95:48]), 8);

    // a different epoch, mid-second
    set_master(64'd123 * SEC_FNS + 64'd500000000 * 64'd65536 + 64'd777);
    wait_s(30);
    n_valid = 0;
    pulse_start();
    wait_s(250);
    chk(n_valid == 1, "R6", n_valid, 1);
    chk(tod_s[95:48] == 48'd123, "R6", longint'(tod_s[95:48]), 123);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule